// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This block is the 32-bit control and status register of a SIMD floating-point unit. It keeps six sticky exception flags and six per-exception mask bits. It also holds a two-bit rounding mode, a flush-to-zero enable and a denormals-are-zero enable, and it drives these control fields out to the arithmetic datapath. Software loads and stores the whole register through a single write port and a read port. The execution lanes report the exceptions each instruction detects through a qualified detection vector. The block then sets the sticky flags and raises a trap request when a newly detected exception is unmasked.

A trap is raised only because an instruction detects something. A software write can leave a flag set while clearing its mask, and that write does not raise a trap. The trap request waits until a later instruction detects that unmasked condition again. The upper sixteen bits are reserved. They read as zero, and a write that tries to set any of them is refused.

Top module: `simd_fp_csr`

## Requirements
- R1: After reset the register reads 0x0000_1F80 (all six masks set, flags clear, rounding mode 00, flush-to-zero and denormals-are-zero off), and trap_req and wr_err are low.
- R2: A write with wr_en high and wr_data[31:16] all zero replaces bits 15:0 of the register. The new value is visible on rd_data from the next cycle. rd_data[31:16] always reads zero.
- R3: A write with any of wr_data[31:16] set leaves the register unchanged and gives a one-cycle wr_err pulse in the next cycle.
- R4: Flag bits 0..5 are invalid, denormal, divide-by-zero, overflow, underflow and precision. A detection (det_valid high, vector det_vec in the same bit order) ORs into the flags. Only a write of zero clears a flag. det_vec has no effect while det_valid is low.
- R5: Mask bits 7..12 follow the flag order, and a set mask bit masks its exception. When a detection is applied, trap_req is high for exactly the next cycle if any detected bit has its mask clear. The flags update in that same cycle.
- R6: A software write never raises trap_req, even when it clears a mask whose flag it sets.
- R7: When a detection arrives in a cycle with wr_en high, the write takes effect and the detection is held back. It is applied in the first later cycle with wr_en low, ORed with any new detection in that cycle. Its flags go on top of the written value, and its trap is judged against the mask now in the register.
- R8: round_mode is bits 14:13 (00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero). flush_zero is bit 15 and denorm_zero is bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current register value, reserved bits zero |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| det_valid | input | 1 | Detection vector qualifier, one per instruction |
| det_vec | input | 6 | Exceptions detected by the instruction |
| trap_req | output | 1 | One-cycle trap request |
| round_mode | output | 2 | Rounding mode to datapath |
| flush_zero | output | 1 | Flush-to-zero enable |
| denorm_zero | output | 1 | Denormals-are-zero enable |

## Verification
A software write and an instruction's detection can fall in the same cycle. The write wins, and the detection must land in a later cycle, judged against the mask that was just written. The bench provokes this collision in a directed case where the written mask unmasks a detected bit. It also provokes it in random runs with back-to-back writes, so that detections pile up across several write cycles. A reference model in the bench judges every cycle. It checks where the held detection reappears in the flags and whether trap_req pulses in that cycle. It also checks that a refused write still delays the detection.

// File: rtl/simd_fp_csr_pkg.sv
// Package: shared field layout, widths and rounding encodings of the
// SIMD floating-point control/status register.
package simd_fp_csr_pkg;
    localparam int NUM_EXC  = 6;
    localparam int CSR_W    = 32;
    localparam int USED_W   = 16;
    localparam int FLAG_LSB = 0;
    localparam int DAZ_BIT  = 6;
    localparam int MASK_LSB = 7;
    localparam int RC_LSB   = 13;
    localparam int RC_W     = 2;
    localparam int FZ_BIT   = 15;

    typedef enum logic [RC_W-1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    // reset image: masks all set, everything else clear
    localparam logic [USED_W-1:0] RESET_IMG =
        {1'b0, RND_NEAR, {NUM_EXC{1'b1}}, 1'b0, {NUM_EXC{1'b0}}};
endpackage

// File: rtl/sfc_wr_screen.sv
// Module: sfc_wr_screen
// Screens software writes. A write is accepted when no reserved bit is set.
// A refused write produces a one-cycle error pulse in the following cycle.
// Assumes: wr_data is stable while wr_en is high at the clock edge.
module sfc_wr_screen #(
    parameter int CSR_W  = 32,
    parameter int USED_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic             wr_accept,
    output logic             wr_err
);
    logic rsv_hit;
    logic err_q;

    assign rsv_hit   = |wr_data[CSR_W-1:USED_W];
    assign wr_accept = wr_en & ~rsv_hit;
    assign wr_err    = err_q;

    // registers the refusal pulse for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= wr_en & rsv_hit;
    end

    // R3: an error pulse only ever follows a write request
    p_err_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));
endmodule

// File: rtl/sfc_ctrl_fields.sv
// Module: sfc_ctrl_fields
// Holds the mask bits, rounding mode, flush-to-zero and denormals-are-zero
// fields. They load only on an accepted software write.
// Assumes: wr_accept already excludes writes with reserved bits set.
module sfc_ctrl_fields
    import simd_fp_csr_pkg::*;
#(
    parameter int N_EXC = NUM_EXC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [N_EXC-1:0] wr_mask,
    input  logic [RC_W-1:0]  wr_rc,
    input  logic             wr_fz,
    input  logic             wr_daz,
    output logic [N_EXC-1:0] mask,
    output rnd_mode_e        rc,
    output logic             fz,
    output logic             daz
);
    // loads control fields on an accepted write, masks set on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
            rc   <= RND_NEAR;
            fz   <= 1'b0;
            daz  <= 1'b0;
        end else if (wr_accept) begin
            mask <= wr_mask;
            rc   <= rnd_mode_e'(wr_rc);
            fz   <= wr_fz;
            daz  <= wr_daz;
        end
    end

    // R2: control fields only move on an accepted write
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_accept) |-> ($stable(mask) && $stable(rc) && $stable(fz) && $stable(daz)));
endmodule

// File: rtl/sfc_exc_track.sv
// Module: sfc_exc_track
// Sticky exception flags, the holding register for detections that collide
// with a software write, and the one-cycle trap request.
// Assumes: any wr_en (accepted or refused) defers detection application.
module sfc_exc_track #(
    parameter int N_EXC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_accept,
    input  logic [N_EXC-1:0] wr_flags,
    input  logic             det_valid,
    input  logic [N_EXC-1:0] det_vec,
    input  logic [N_EXC-1:0] mask,
    output logic [N_EXC-1:0] flags,
    output logic             trap_req
);
    logic [N_EXC-1:0] pend_q;
    logic [N_EXC-1:0] gated_det;
    logic [N_EXC-1:0] eff_det;
    logic             apply_en;
    logic             trap_q;

    assign gated_det = det_valid ? det_vec : '0;
    assign eff_det   = pend_q | gated_det;
    assign apply_en  = ~wr_en;
    assign trap_req  = trap_q;

    // accumulates detections while writes keep arriving
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= '0;
        else if (wr_en)  pend_q <= eff_det;
        else             pend_q <= '0;
    end

    // one sticky flag per exception
    for (genvar i = 0; i < N_EXC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (wr_accept) flags[i] <= wr_flags[i];
            else if (apply_en)  flags[i] <= flags[i] | eff_det[i];
        end
    end

    // raises the trap only for newly applied, unmasked detections
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= apply_en & |(eff_det & ~mask);
    end

    // R4: without a write, flags never lose a set bit
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_accept) |-> ((flags & $past(flags)) == $past(flags)));
    // R5: a trap coincides with an unmasked flag being set
    p_trap_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (|(flags & ~mask)));
    // R6: the cycle after a write never carries a trap
    p_no_trap_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> !trap_req);
    // R7: a held detection lands in the flags once writes stop
    p_defer_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && |pend_q) |=> ((flags & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/simd_fp_csr.sv
// Module: simd_fp_csr
// Top of the SIMD floating-point control/status register: write screening,
// control fields and exception tracking, assembled into a 32-bit read view.
// Assumes: one detection vector per cycle at most, qualified by det_valid.
module simd_fp_csr
    import simd_fp_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CSR_W-1:0]     wr_data,
    output logic [CSR_W-1:0]     rd_data,
    output logic                 wr_err,
    input  logic                 det_valid,
    input  logic [NUM_EXC-1:0]   det_vec,
    output logic                 trap_req,
    output logic [RC_W-1:0]      round_mode,
    output logic                 flush_zero,
    output logic                 denorm_zero
);
    localparam int RSV_W = CSR_W - USED_W;

    logic               wr_accept;
    logic [NUM_EXC-1:0] mask;
    logic [NUM_EXC-1:0] flags;
    rnd_mode_e          rc;
    logic               fz;
    logic               daz;

    sfc_wr_screen #(.CSR_W(CSR_W), .USED_W(USED_W)) u_screen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_accept (wr_accept),
        .wr_err    (wr_err)
    );

    sfc_ctrl_fields #(.N_EXC(NUM_EXC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .wr_mask   (wr_data[MASK_LSB +: NUM_EXC]),
        .wr_rc     (wr_data[RC_LSB +: RC_W]),
        .wr_fz     (wr_data[FZ_BIT]),
        .wr_daz    (wr_data[DAZ_BIT]),
        .mask      (mask),
        .rc        (rc),
        .fz        (fz),
        .daz       (daz)
    );

    sfc_exc_track #(.N_EXC(NUM_EXC)) u_exc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_accept (wr_accept),
        .wr_flags  (wr_data[FLAG_LSB +: NUM_EXC]),
        .det_valid (det_valid),
        .det_vec   (det_vec),
        .mask      (mask),
        .flags     (flags),
        .trap_req  (trap_req)
    );

    // read view: reserved half forced to zero
    assign rd_data     = {{RSV_W{1'b0}}, fz, rc, mask, daz, flags};
    assign round_mode  = rc;
    assign flush_zero  = fz;
    assign denorm_zero = daz;

    // R1: the cycle after reset the register shows its reset image
    p_reset_img_r1: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (rd_data == {{RSV_W{1'b0}}, RESET_IMG}));
    // R3: a refused write leaves the register untouched
    p_refused_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> (rd_data == $past(rd_data)));
endmodule

// File: tb/simd_fp_csr_tb.sv
`timescale 1ns/1ps
module simd_fp_csr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wr_err;
    logic        det_valid = 1'b0;
    logic [5:0]  det_vec = '0;
    logic        trap_req;
    logic [1:0]  round_mode;
    logic        flush_zero;
    logic        denorm_zero;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_reg;
    logic [5:0]  m_pend;
    logic        m_trap;
    logic        m_err;

    always #2 clk = ~clk;

    simd_fp_csr u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wr_err(wr_err), .det_valid(det_valid),
        .det_vec(det_vec), .trap_req(trap_req), .round_mode(round_mode),
        .flush_zero(flush_zero), .denorm_zero(denorm_zero)
    );

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // advances the reference model by one cycle from the applied inputs
    function automatic void model_step(logic we, logic [31:0] wd, logic dv, logic [5:0] dvec);
        logic [5:0] eff;
        eff = m_pend | (dv ? dvec : 6'h0);
        if (we) begin
            m_err  = |wd[31:16];
            if (!m_err) m_reg = wd[15:0];
            m_pend = eff;
            m_trap = 1'b0;
        end else begin
            m_err  = 1'b0;
            m_trap = |(eff & ~m_reg[12:7]);
            m_reg[5:0] = m_reg[5:0] | eff;
            m_pend = '0;
        end
    endfunction

    task automatic compare_all(string tag);
        chk(tag, "rd_data", rd_data, {16'h0, m_reg});
        chk(tag, "trap_req", {31'h0, trap_req}, {31'h0, m_trap});
        chk(tag, "wr_err", {31'h0, wr_err}, {31'h0, m_err});
        chk(tag, "round_mode", {30'h0, round_mode}, {30'h0, m_reg[14:13]});
        chk(tag, "flush_zero", {31'h0, flush_zero}, {31'h0, m_reg[15]});
        chk(tag, "denorm_zero", {31'h0, denorm_zero}, {31'h0, m_reg[6]});
    endtask

    // drives one cycle at the falling edge, checks at the next falling edge
    task automatic cyc(logic we, logic [31:0] wd, logic dv, logic [5:0] dvec, string tag);
        wr_en = we; wr_data = wd; det_valid = dv; det_vec = dvec;
        @(posedge clk);
        model_step(we, wd, dv, dvec);
        @(negedge clk);
        wr_en = 1'b0; det_valid = 1'b0;
        compare_all(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_reg = 16'h1F80; m_pend = '0; m_trap = 0; m_err = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R8: rounding toward plus infinity, flush-to-zero and DAZ on
        cyc(1, 32'h0000_DFC0, 0, 0, "R8");
        cyc(1, 32'h0000_3F80, 0, 0, "R2");
        // R3: reserved bit set is refused
        cyc(1, 32'h0001_0000, 0, 0, "R3");
        cyc(0, 0, 0, 0, "R3");
        // R4: masked detection sets flags, no trap
        cyc(0, 0, 1, 6'h05, "R4");
        cyc(0, 0, 0, 6'h3F, "R4");
        // R6: unmask all while invalid flag set: no trap
        cyc(1, 32'h0000_0001, 0, 0, "R6");
        cyc(0, 0, 0, 0, "R6");
        // R5: unmasked overflow detection traps for one cycle
        cyc(0, 0, 1, 6'h08, "R5");
        cyc(0, 0, 0, 0, "R5");
        // R7: collision, write unmasks invalid, detection held
        cyc(1, 32'h0000_1F00, 1, 6'h03, "R7");
        cyc(0, 0, 0, 0, "R7");
        // R7: held across a refused write, then merged with a new detection
        cyc(1, 32'h0000_1F80, 1, 6'h10, "R7");
        cyc(1, 32'h0002_0000, 1, 6'h20, "R7");
        cyc(0, 0, 1, 6'h01, "R7");
        // R4: a write of zero clears flags
        cyc(1, 32'h0000_0F80, 0, 0, "R4");

        for (int i = 0; i < 400; i++) begin
            logic we, dv;
            logic [31:0] wd;
            we = ($urandom % 100) < 35;
            wd = {16'h0, 16'($urandom)};
            if (($urandom % 100) < 15) wd[31:16] = 16'($urandom) | 16'h0001;
            dv = ($urandom % 100) < 55;
            cyc(we, wd, dv, 6'($urandom), "R2/R3/R4/R5/R7");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule